// File: doc/BRIEF.md
# Interrupt Input Servicing and End-of-Interrupt Tracking

This block watches a set of interrupt input wires and decides when each one should produce a delivery request toward the processors. Every input has its own routing entry, which holds a mask, a polarity, an edge or level trigger select, a vector, a destination and a delivery mode. The block also keeps two bits of state per input. The pending bit records that the input is currently asserted. The in-service bit records that a level-triggered interrupt was accepted and has not yet been acknowledged.

Triggers come from three places: a rising effective level on an input, a service request from the register block, and an end-of-interrupt broadcast carrying a vector. Each trigger marks the input as a service candidate. A dispatcher takes one candidate per cycle, always the lowest-numbered input first. For each candidate it either starts a delivery or discards the candidate, and it never has more than one delivery outstanding. A delivery is held on the outputs until the downstream side acknowledges it. The acknowledge reports whether any processor took the interrupt.

Top module: `irq_svc_core`

## Requirements
- R1: After reset, all pending bits, all in-service bits and the delivery request are 0.
- R2: The effective level of an input is its raw level XOR its polarity bit. A rising effective level sets the pending bit one cycle later. An inactive effective level clears it one cycle later.
- R3: An edge-triggered input (trigger bit 0) that becomes active while unmasked produces exactly one delivery. That delivery carries the entry's vector, destination and mode, and level flag 0. The pending bit is cleared when the input is serviced. An accepted delivery leaves the in-service bit at 0.
- R4: A level-triggered input (trigger bit 1) whose delivery is acknowledged as accepted gets its in-service bit set. While that bit is set, a new rising level produces no delivery.
- R5: A level-triggered delivery acknowledged as not accepted (no target found) leaves the in-service bit at 0.
- R6: A masked input produces no delivery. If it is edge-triggered, servicing still clears its pending bit. If it is level-triggered, the pending bit stays set while the level is held.
- R7: A level end-of-interrupt (end-of-interrupt level flag 1) clears the in-service bit of every input whose vector matches. Each matching input that is unmasked and still pending is then delivered again, in ascending input order.
- R8: An end-of-interrupt with a vector that matches no entry, or one whose level flag is 0, leaves every in-service bit unchanged.
- R9: Mode codes 3'b000 (fixed), 3'b001 (lowest priority) and 3'b100 (non-maskable) are delivered with the mode passed through unchanged. Any other code is dropped without a delivery.
- R10: A delivery from input 0 has destination 0 and the force-processor-0 flag set, whatever its destination field holds. Deliveries from other inputs carry their destination field and the flag at 0.
- R11: While a delivery waits for its acknowledge, the request and its fields stay unchanged. Other candidates wait until the acknowledge has been seen.
- R12: A service request pulse on a pending, unmasked input produces a delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_raw | input | N | Raw input levels |
| ent_mask | input | N | Per-input mask |
| ent_pol | input | N | Per-input polarity (1 = active low) |
| ent_lvl | input | N | Per-input trigger select (1 = level) |
| ent_vec | input | N*VW | Per-input vector, input i at bits [i*VW +: VW] |
| ent_dest | input | N*DW | Per-input destination field |
| ent_mode | input | N*3 | Per-input delivery mode code |
| svc_req | input | N | Service request pulses from the register block |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_level | input | 1 | End-of-interrupt refers to a level interrupt |
| eoi_vec | input | VW | End-of-interrupt vector |
| dlv_req | output | 1 | Delivery request, held until acknowledged |
| dlv_pin | output | PW | Input number of the delivery |
| dlv_vector | output | VW | Vector of the delivery |
| dlv_dest | output | DW | Destination of the delivery |
| dlv_mode | output | 3 | Delivery mode code |
| dlv_level | output | 1 | Delivery is level-triggered |
| dlv_force0 | output | 1 | Destination is forced to processor 0 |
| dlv_ack | input | 1 | Acknowledge of the current delivery |
| dlv_accepted | input | 1 | Acknowledged delivery reached at least one processor |
| pending | output | N | Pending bit of each input |
| in_service | output | N | In-service bit of each input |

## Verification
Random single-input stimulus uses edge entries with random polarity, vector, destination, mode and mask. It separates deliverable mode codes from dropped ones, and masked entries from unmasked ones. Directed patterns cover the rest of the behaviour. A level input re-asserted while in service shows that the in-service gate works. A matching end-of-interrupt on two inputs that share one vector must give two redeliveries in ascending order, while a non-matching or edge-flagged end-of-interrupt must give none. Two inputs raised in the same cycle, with the acknowledge withheld, show that only one delivery is outstanding at a time. Input 0 given a nonzero destination field shows the forced routing.

// File: rtl/irq_svc_pkg.sv
// Shared constants and helpers for the interrupt servicing block.
// Assumes a 3-bit delivery mode code.
package irq_svc_pkg;

    localparam logic [2:0] MODE_FIXED  = 3'b000;
    localparam logic [2:0] MODE_LOWPRI = 3'b001;
    localparam logic [2:0] MODE_NMI    = 3'b100;

    // True when a mode code leads to a delivery.
    function automatic logic mode_deliverable(input logic [2:0] m);
        return (m == MODE_FIXED) || (m == MODE_LOWPRI) || (m == MODE_NMI);
    endfunction

endpackage

// File: rtl/irq_pin_slot.sv
// State for one interrupt input: effective-level history, pending bit,
// in-service bit and the service-candidate flag.
// Assumes the dispatcher picks at most one slot per cycle. If an accept
// and an end-of-interrupt hit land in the same cycle, the accept wins.
module irq_pin_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol,
    input  logic lvl,
    input  logic mask,
    input  logic eoi_hit,
    input  logic reg_svc,
    input  logic pick,
    input  logic acc_set,
    output logic pending,
    output logic in_service,
    output logic want
);
    logic eff;
    logic eff_q;
    logic rise;
    logic rise_svc;

    assign eff      = raw ^ pol;
    assign rise     = eff & ~eff_q;
    assign rise_svc = rise & ((~lvl & ~pending) | ~in_service);

    // Remember the previous effective level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eff_q <= 1'b0;
        else        eff_q <= eff;
    end

    // Pending bit: set on a rise, cleared by an inactive level or an edge service.
    always_ff @(posedge clk) begin
        if (!rst_n)           pending <= 1'b0;
        else if (!eff)        pending <= 1'b0;
        else if (rise)        pending <= 1'b1;
        else if (pick && !lvl) pending <= 1'b0;
    end

    // In-service bit: set by an accepted level delivery, cleared by a matching EOI.
    always_ff @(posedge clk) begin
        if (!rst_n)       in_service <= 1'b0;
        else if (acc_set) in_service <= 1'b1;
        else if (eoi_hit) in_service <= 1'b0;
    end

    // Candidate flag: raised by any trigger, dropped when the dispatcher picks it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            want <= 1'b0;
        else if (rise_svc || (eoi_hit && !mask && pending) || (reg_svc && pending))
            want <= 1'b1;
        else if (pick)
            want <= 1'b0;
    end

endmodule

// File: rtl/irq_eoi_match.sv
// Compares an end-of-interrupt vector against every entry at once and
// flags all matches. Edge-flagged broadcasts match nothing.
module irq_eoi_match #(
    parameter int N  = 24,
    parameter int VW = 8
) (
    input  logic            eoi_valid,
    input  logic            eoi_level,
    input  logic [VW-1:0]   eoi_vec,
    input  logic [N*VW-1:0] ent_vec,
    output logic [N-1:0]    hit
);
    // One comparator per entry.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = eoi_valid & eoi_level & (ent_vec[i*VW +: VW] == eoi_vec);
    end

endmodule

// File: rtl/irq_dispatch.sv
// Takes the lowest-numbered candidate when idle, drops it if it is masked
// or its mode is not deliverable, and otherwise holds a delivery request
// until acknowledged. Input 0 is always routed to processor 0.
module irq_dispatch
    import irq_svc_pkg::*;
#(
    parameter int N  = 24,
    parameter int VW = 8,
    parameter int DW = 8,
    parameter int PW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    want,
    input  logic [N-1:0]    mask,
    input  logic [N-1:0]    lvl,
    input  logic [N*VW-1:0] ent_vec,
    input  logic [N*DW-1:0] ent_dest,
    input  logic [N*3-1:0]  ent_mode,
    input  logic            dlv_ack,
    input  logic            dlv_accepted,
    output logic [N-1:0]    pick,
    output logic [N-1:0]    acc_set,
    output logic            dlv_req,
    output logic [PW-1:0]   dlv_pin,
    output logic [VW-1:0]   dlv_vector,
    output logic [DW-1:0]   dlv_dest,
    output logic [2:0]      dlv_mode,
    output logic            dlv_level,
    output logic            dlv_force0
);
    logic          busy;
    logic          sel_any;
    logic [PW-1:0] sel_idx;
    logic          sel_ok;
    logic [2:0]    sel_mode;

    // Priority encoder: find the lowest-numbered candidate.
    always_comb begin
        sel_any = 1'b0;
        sel_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (want[i]) begin
                sel_any = 1'b1;
                sel_idx = PW'(i);
            end
        end
    end

    assign sel_mode = ent_mode[int'(sel_idx)*3 +: 3];
    assign sel_ok   = !mask[sel_idx] && mode_deliverable(sel_mode);
    assign pick     = (!busy && sel_any) ? (N'(1) << sel_idx) : '0;
    assign acc_set  = (busy && dlv_ack && dlv_accepted && dlv_level) ? (N'(1) << dlv_pin) : '0;
    assign dlv_req  = busy;

    // Delivery register: load on a deliverable pick, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            dlv_pin    <= '0;
            dlv_vector <= '0;
            dlv_dest   <= '0;
            dlv_mode   <= MODE_FIXED;
            dlv_level  <= 1'b0;
            dlv_force0 <= 1'b0;
        end else if (busy) begin
            if (dlv_ack) busy <= 1'b0;
        end else if (sel_any && sel_ok) begin
            busy       <= 1'b1;
            dlv_pin    <= sel_idx;
            dlv_vector <= ent_vec[int'(sel_idx)*VW +: VW];
            dlv_dest   <= (sel_idx == '0) ? '0 : ent_dest[int'(sel_idx)*DW +: DW];
            dlv_mode   <= sel_mode;
            dlv_level  <= lvl[sel_idx];
            dlv_force0 <= (sel_idx == '0);
        end
    end

endmodule

// File: rtl/irq_svc_core.sv
// Top of the interrupt servicing block: one state slot per input, a
// parallel end-of-interrupt vector matcher and a single-outstanding
// dispatcher. Entries are held outside this block and are assumed stable
// while their input is being serviced.
module irq_svc_core #(
    parameter  int N  = 24,
    parameter  int VW = 8,
    parameter  int DW = 8,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    irq_raw,
    input  logic [N-1:0]    ent_mask,
    input  logic [N-1:0]    ent_pol,
    input  logic [N-1:0]    ent_lvl,
    input  logic [N*VW-1:0] ent_vec,
    input  logic [N*DW-1:0] ent_dest,
    input  logic [N*3-1:0]  ent_mode,
    input  logic [N-1:0]    svc_req,
    input  logic            eoi_valid,
    input  logic            eoi_level,
    input  logic [VW-1:0]   eoi_vec,
    output logic            dlv_req,
    output logic [PW-1:0]   dlv_pin,
    output logic [VW-1:0]   dlv_vector,
    output logic [DW-1:0]   dlv_dest,
    output logic [2:0]      dlv_mode,
    output logic            dlv_level,
    output logic            dlv_force0,
    input  logic            dlv_ack,
    input  logic            dlv_accepted,
    output logic [N-1:0]    pending,
    output logic [N-1:0]    in_service
);
    logic [N-1:0] eoi_hit;
    logic [N-1:0] want;
    logic [N-1:0] pick;
    logic [N-1:0] acc_set;

    irq_eoi_match #(.N(N), .VW(VW)) u_eoi (
        .eoi_valid (eoi_valid),
        .eoi_level (eoi_level),
        .eoi_vec   (eoi_vec),
        .ent_vec   (ent_vec),
        .hit       (eoi_hit)
    );

    // One state slot per interrupt input.
    for (genvar i = 0; i < N; i++) begin : g_slot
        irq_pin_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw        (irq_raw[i]),
            .pol        (ent_pol[i]),
            .lvl        (ent_lvl[i]),
            .mask       (ent_mask[i]),
            .eoi_hit    (eoi_hit[i]),
            .reg_svc    (svc_req[i]),
            .pick       (pick[i]),
            .acc_set    (acc_set[i]),
            .pending    (pending[i]),
            .in_service (in_service[i]),
            .want       (want[i])
        );
    end

    irq_dispatch #(.N(N), .VW(VW), .DW(DW), .PW(PW)) u_disp (
        .clk          (clk),
        .rst_n        (rst_n),
        .want         (want),
        .mask         (ent_mask),
        .lvl          (ent_lvl),
        .ent_vec      (ent_vec),
        .ent_dest     (ent_dest),
        .ent_mode     (ent_mode),
        .dlv_ack      (dlv_ack),
        .dlv_accepted (dlv_accepted),
        .pick         (pick),
        .acc_set      (acc_set),
        .dlv_req      (dlv_req),
        .dlv_pin      (dlv_pin),
        .dlv_vector   (dlv_vector),
        .dlv_dest     (dlv_dest),
        .dlv_mode     (dlv_mode),
        .dlv_level    (dlv_level),
        .dlv_force0   (dlv_force0)
    );

endmodule

// File: rtl/irq_svc_checker.sv
// Protocol and state checks for irq_svc_core, attached with bind.
// Assumes the synchronous active-low reset of the top module.
module irq_svc_checker #(
    parameter int N  = 24,
    parameter int VW = 8,
    parameter int DW = 8,
    parameter int PW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dlv_req,
    input logic [PW-1:0] dlv_pin,
    input logic [VW-1:0] dlv_vector,
    input logic [DW-1:0] dlv_dest,
    input logic [2:0]    dlv_mode,
    input logic          dlv_level,
    input logic          dlv_force0,
    input logic          dlv_ack,
    input logic          dlv_accepted,
    input logic [N-1:0]  in_service
);
    // R11: an unacknowledged request holds with stable fields
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_req && !dlv_ack) |=> (dlv_req && $stable(dlv_pin) && $stable(dlv_vector)
                                   && $stable(dlv_dest) && $stable(dlv_mode)));

    // R9: only deliverable mode codes appear on a request
    a_r9_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_req |-> (dlv_mode == 3'b000 || dlv_mode == 3'b001 || dlv_mode == 3'b100));

    // R10: input 0 always goes to processor 0
    a_r10_pin0_cpu0: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_req && dlv_pin == '0) |-> (dlv_dest == '0 && dlv_force0));

    // R4: an in-service bit is only raised by an accepted level acknowledge
    a_r4_isr_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_service & ~$past(in_service)) != '0) |->
            $past(dlv_req && dlv_ack && dlv_accepted && dlv_level));

    // R11: at most one in-service bit is raised per cycle
    a_r11_one_isr_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_service & ~$past(in_service)) <= 1);

endmodule

bind irq_svc_core irq_svc_checker #(.N(N), .VW(VW), .DW(DW), .PW(PW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dlv_req      (dlv_req),
    .dlv_pin      (dlv_pin),
    .dlv_vector   (dlv_vector),
    .dlv_dest     (dlv_dest),
    .dlv_mode     (dlv_mode),
    .dlv_level    (dlv_level),
    .dlv_force0   (dlv_force0),
    .dlv_ack      (dlv_ack),
    .dlv_accepted (dlv_accepted),
    .in_service   (in_service)
);

// File: tb/tb_irq_svc_core.sv
// Bench for irq_svc_core: directed corner cases and seeded random edge traffic.
module tb_irq_svc_core;
    localparam int N  = 24;
    localparam int VW = 8;
    localparam int DW = 8;
    localparam int PW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq_raw = '0;
    logic [N-1:0]    ent_mask = '0;
    logic [N-1:0]    ent_pol = '0;
    logic [N-1:0]    ent_lvl = '0;
    logic [N*VW-1:0] ent_vec = '0;
    logic [N*DW-1:0] ent_dest = '0;
    logic [N*3-1:0]  ent_mode = '0;
    logic [N-1:0]    svc_req = '0;
    logic            eoi_valid = 1'b0;
    logic            eoi_level = 1'b0;
    logic [VW-1:0]   eoi_vec = '0;
    logic            dlv_req;
    logic [PW-1:0]   dlv_pin;
    logic [VW-1:0]   dlv_vector;
    logic [DW-1:0]   dlv_dest;
    logic [2:0]      dlv_mode;
    logic            dlv_level;
    logic            dlv_force0;
    logic            dlv_ack = 1'b0;
    logic            dlv_accepted = 1'b0;
    logic [N-1:0]    pending;
    logic [N-1:0]    in_service;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    irq_svc_core #(.N(N), .VW(VW), .DW(DW)) dut (.*);

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000 && !done) begin
            n_fail = n_fail + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_entry(input int p, input bit m, input bit po, input bit lv,
                             input logic [7:0] v, input logic [7:0] d, input logic [2:0] md);
        ent_mask[p] = m;
        ent_pol[p]  = po;
        ent_lvl[p]  = lv;
        ent_vec[p*VW +: VW]  = v;
        ent_dest[p*DW +: DW] = d;
        ent_mode[p*3 +: 3]   = md;
        irq_raw[p] = po;
    endtask

    task automatic raise(input int p);
        irq_raw[p] = ~ent_pol[p];
    endtask

    task automatic lower(input int p);
        irq_raw[p] = ent_pol[p];
    endtask

    task automatic wait_dlv(output bit seen, input int maxc);
        seen = 0;
        for (int i = 0; i < maxc && !seen; i++) begin
            step(1);
            if (dlv_req) seen = 1;
        end
    endtask

    task automatic ack(input bit acc);
        dlv_ack = 1'b1;
        dlv_accepted = acc;
        step(1);
        dlv_ack = 1'b0;
        dlv_accepted = 1'b0;
    endtask

    task automatic eoi(input bit lv, input logic [7:0] v);
        eoi_valid = 1'b1;
        eoi_level = lv;
        eoi_vec = v;
        step(1);
        eoi_valid = 1'b0;
    endtask

    function automatic bit exp_deliver(input logic [2:0] md, input bit m);
        return !m && (md == 3'b000 || md == 3'b001 || md == 3'b100);
    endfunction

    initial begin
        bit seen;
        void'($urandom(32'h5eed_1234));
        step(3);
        chk(pending == '0 && in_service == '0 && !dlv_req, "R1 reset state",
            {7'd0, dlv_req, pending}, 32'd0);
        rst_n = 1'b1;
        step(2);

        // R3: edge delivery on input 6
        set_entry(6, 0, 0, 0, 8'h31, 8'h07, 3'b000);
        step(1); raise(6);
        wait_dlv(seen, 6);
        chk(seen && dlv_pin == 5'd6 && dlv_vector == 8'h31 && dlv_dest == 8'h07
            && dlv_mode == 3'b000 && !dlv_level && !dlv_force0,
            "R3 edge delivery fields", {dlv_pin, dlv_vector, dlv_dest}, {5'd6, 8'h31, 8'h07});
        chk(pending[6] == 1'b0, "R3 edge pending cleared on service", pending[6], 0);
        ack(1);
        chk(in_service[6] == 1'b0, "R3 edge accept leaves in-service clear", in_service[6], 0);
        wait_dlv(seen, 4);
        chk(!seen, "R3 exactly one delivery", seen, 0);
        lower(6); step(2);

        // R10: input 0 forced to processor 0; another input passes its destination
        set_entry(0, 0, 0, 0, 8'h20, 8'h5A, 3'b000);
        step(1); raise(0);
        wait_dlv(seen, 6);
        chk(seen && dlv_pin == 0 && dlv_dest == 8'h00 && dlv_force0, "R10 input 0 to processor 0",
            {dlv_force0, dlv_dest}, {1'b1, 8'h00});
        ack(1); lower(0); step(2);
        set_entry(1, 0, 0, 0, 8'h21, 8'h5A, 3'b001);
        step(1); raise(1);
        wait_dlv(seen, 6);
        chk(seen && dlv_dest == 8'h5A && !dlv_force0 && dlv_mode == 3'b001,
            "R10 R9 other input keeps destination, lowest-priority mode",
            {dlv_force0, dlv_dest}, {1'b0, 8'h5A});
        ack(1); lower(1); step(2);

        // R9: NMI passes, code 3'b010 dropped
        set_entry(2, 0, 0, 0, 8'h22, 8'h01, 3'b100);
        step(1); raise(2);
        wait_dlv(seen, 6);
        chk(seen && dlv_mode == 3'b100, "R9 non-maskable mode delivered", dlv_mode, 3'b100);
        ack(1); lower(2); step(2);
        set_entry(2, 0, 0, 0, 8'h22, 8'h01, 3'b010);
        step(1); raise(2);
        wait_dlv(seen, 6);
        chk(!seen, "R9 unsupported mode dropped", seen, 0);
        lower(2); step(2);

        // R2 + R6: active-low level input, masked
        set_entry(4, 1, 1, 1, 8'h44, 8'h02, 3'b000);
        step(2); raise(4); step(1);
        chk(pending[4] == 1'b1, "R2 inverted polarity sets pending", pending[4], 1);
        wait_dlv(seen, 5);
        chk(!seen && pending[4], "R6 masked level: no delivery, pending held",
            {seen, pending[4]}, {1'b0, 1'b1});
        lower(4); step(1);
        chk(pending[4] == 1'b0, "R2 inactive level clears pending", pending[4], 0);

        // R6: masked edge input has pending cleared by its service
        set_entry(8, 1, 0, 0, 8'h48, 8'h02, 3'b000);
        step(1); raise(8); step(1);
        chk(pending[8] == 1'b1, "R6 masked edge pending set", pending[8], 1);
        wait_dlv(seen, 4);
        chk(!seen && pending[8] == 1'b0, "R6 masked edge: no delivery, pending cleared",
            {seen, pending[8]}, 0);
        lower(8); step(2);

        // R12: unmask pending level input 4, request service
        raise(4); step(3);
        ent_mask[4] = 1'b0;
        svc_req[4] = 1'b1; step(1); svc_req[4] = 1'b0;
        wait_dlv(seen, 5);
        chk(seen && dlv_pin == 5'd4 && dlv_level, "R12 service request delivers pending input",
            dlv_pin, 4);
        ack(1);
        chk(in_service[4] == 1'b1, "R4 accepted level sets in-service", in_service[4], 1);
        // R4: re-rise while in service gives nothing
        lower(4); step(2); raise(4);
        wait_dlv(seen, 5);
        chk(!seen && pending[4], "R4 in-service gates new rise", seen, 0);
        // R8: non-matching and edge-flagged EOI
        eoi(1, 8'h45);
        chk(in_service[4] == 1'b1, "R8 non-matching EOI ignored", in_service[4], 1);
        eoi(0, 8'h44);
        chk(in_service[4] == 1'b1, "R8 edge-flagged EOI ignored", in_service[4], 1);
        wait_dlv(seen, 4);
        chk(!seen, "R8 no redelivery after ignored EOI", seen, 0);
        // R7: matching level EOI redelivers
        eoi(1, 8'h44);
        chk(in_service[4] == 1'b0, "R7 matching EOI clears in-service", in_service[4], 0);
        wait_dlv(seen, 4);
        chk(seen && dlv_pin == 5'd4, "R7 redelivery of still-pending input", dlv_pin, 4);
        ack(0);
        chk(in_service[4] == 1'b0, "R5 not-accepted level leaves in-service clear",
            in_service[4], 0);
        lower(4); step(2);

        // R7: two inputs share a vector, redelivered in ascending order
        set_entry(9, 0, 0, 1, 8'h50, 8'h03, 3'b000);
        set_entry(5, 0, 0, 1, 8'h50, 8'h03, 3'b000);
        step(1); raise(9);
        wait_dlv(seen, 6); ack(1);
        raise(5);
        wait_dlv(seen, 6); ack(1);
        chk(in_service[5] && in_service[9], "R4 both level inputs in service",
            {in_service[9], in_service[5]}, 2'b11);
        eoi(1, 8'h50);
        wait_dlv(seen, 4);
        chk(seen && dlv_pin == 5'd5, "R7 first match is lower input", dlv_pin, 5);
        ack(1);
        wait_dlv(seen, 4);
        chk(seen && dlv_pin == 5'd9, "R7 second match follows", dlv_pin, 9);
        ack(1);
        lower(5); lower(9); step(2);

        // R11: two simultaneous edges, acknowledge withheld
        set_entry(3, 0, 0, 0, 8'h63, 8'h04, 3'b000);
        set_entry(7, 0, 0, 0, 8'h67, 8'h04, 3'b000);
        step(1); raise(3); raise(7);
        wait_dlv(seen, 6);
        step(4);
        chk(dlv_req && dlv_pin == 5'd3 && dlv_vector == 8'h63, "R11 request held, lower input first",
            {dlv_pin, dlv_vector}, {5'd3, 8'h63});
        ack(1);
        wait_dlv(seen, 4);
        chk(seen && dlv_pin == 5'd7, "R11 second delivery after acknowledge", dlv_pin, 7);
        ack(1); lower(3); lower(7); step(2);

        // Random edge traffic (R3 R6 R9)
        for (int k = 0; k < 60; k++) begin
            int p;
            logic [2:0] md;
            logic [7:0] v;
            logic [7:0] d;
            bit m;
            bit po;
            bit acc;
            p  = 10 + int'($urandom_range(0, N - 11));
            md = 3'($urandom_range(0, 7));
            v  = 8'($urandom);
            d  = 8'($urandom);
            m  = ($urandom_range(0, 3) == 0);
            po = 1'($urandom);
            acc = 1'($urandom);
            set_entry(p, m, po, 0, v, d, md);
            step(1); raise(p);
            wait_dlv(seen, 6);
            chk(seen == exp_deliver(md, m), "R9 R6 random delivery decision",
                seen, exp_deliver(md, m));
            if (seen) begin
                chk(dlv_pin == PW'(p) && dlv_vector == v && dlv_dest == d && dlv_mode == md
                    && !dlv_level, "R3 random delivery fields",
                    {dlv_pin, dlv_vector, dlv_dest}, {5'(p), v, d});
                ack(acc);
            end
            chk(pending[p] == 1'b0 && in_service[p] == 1'b0, "R3 random edge state after service",
                {pending[p], in_service[p]}, 0);
            lower(p); step(2);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule